// File: doc/BRIEF.md
# Retention Power-Gating Sleep Sequencer

This controller steps a power-gated logic domain through four periods: active, capture, hold and restore. Capture and restore are the only transitional periods. While the domain runs, its supply is on, the retention switches are open and each state node is driven by its normal logic. A sleep request first freezes the distributed clock. The controller then closes the retention switches for a timed capture window, cuts the supply for the hold period, and later runs a timed restore window. In that window the retention elements drive the nodes while the normal drivers are held apart from them.

The two retention controls, the switch close and the capture gate, are both decoded from the same period state that sets the supply enable. A retention cell therefore needs only these two wires. Each window length is a cycle count sampled when the window starts. The integrator picks each count so that the window spans at least the worst skew between the two controls plus the minimum capture or restore time of a retention cell.

Top module: `retention_sleep_seq`

## Requirements
- R1: After reset, phase is 0 (active), pwr_en=1, sw_close=0, cap_gate=0, iso_pass=1, clk_freeze=0 and done=0.
- R2: A sleep_req sampled in active with clk_freeze low raises clk_freeze after that edge while phase stays 0. At the next edge phase becomes 1 (capture). Phase codes: 0 active, 1 capture, 2 hold, 3 restore.
- R3: sw_close is high exactly when phase is 1 or 3.
- R4: cap_gate is high exactly when phase is 2 or 3. It is low in active and capture.
- R5: pwr_en is low exactly when phase is 2.
- R6: iso_pass is low exactly when phase is 3. It goes high in the same cycle that phase returns to 0.
- R7: clk_freeze stays high from the lead cycle through the last restore cycle. It drops in the same cycle that phase returns to 0.
- R8: Capture lasts cap_len cycles and restore lasts rst_len cycles. Each count is sampled on entry to its window, so later changes have no effect on a window already running. A count of 0 acts as 1.
- R9: Hold lasts until wake_req is seen in hold. A wake_req seen during capture is kept pending, and then hold lasts exactly one cycle before restore begins.
- R10: done is a one-cycle pulse in the first cycle of hold and in the first cycle of active after restore.
- R11: sleep_req has no effect outside active, and wake_req has no effect in active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Request to enter sleep |
| wake_req | input | 1 | Request to leave sleep |
| cap_len | input | CNT_W | Capture window length in cycles |
| rst_len | input | CNT_W | Restore window length in cycles |
| pwr_en | output | 1 | Domain supply enable |
| sw_close | output | 1 | Retention switch close |
| cap_gate | output | 1 | Retention loop gate on |
| iso_pass | output | 1 | Normal driver connected to retained node |
| clk_freeze | output | 1 | Request to hold the distributed clock |
| phase | output | 2 | Current period code |
| done | output | 1 | Pulse on reaching hold or active |

## Verification
The bench targets four corner cases.

- **Wake during capture.** A wake arriving mid-capture must be remembered. A design that drops it would sit in hold forever. A design that acts on it early would cut capture short.
- **Zero-length windows.** A zero count must still give one cycle. A wrong design would hang or wrap its counter.
- **Count changed mid-window.** A count changed while its window runs must not stretch or shorten that window.
- **Release order.** The clock freeze and isolation release must fall on the exact cycle of the return to active. A design that releases one cycle early would let the normal driver fight the restoring retention cell.

// File: rtl/slp_seq_pkg.sv
package slp_seq_pkg;
   typedef enum logic [1:0] {
      PH_ACTIVE  = 2'd0,
      PH_CAPTURE = 2'd1,
      PH_HOLD    = 2'd2,
      PH_RESTORE = 2'd3
   } slp_phase_e;

   typedef struct packed {
      logic pwr_en;
      logic sw_close;
      logic cap_gate;
      logic iso_pass;
   } slp_ctrl_t;

   localparam slp_ctrl_t CTRL_RESET = '{pwr_en: 1'b1, sw_close: 1'b0,
                                        cap_gate: 1'b0, iso_pass: 1'b1};

   function automatic slp_ctrl_t slp_decode(input slp_phase_e ph);
      slp_ctrl_t c;
      c.pwr_en   = (ph != PH_HOLD);
      c.sw_close = (ph == PH_CAPTURE) || (ph == PH_RESTORE);
      c.cap_gate = (ph == PH_HOLD) || (ph == PH_RESTORE);
      c.iso_pass = (ph != PH_RESTORE);
      return c;
   endfunction
endpackage

// File: rtl/slp_window_timer.sv
module slp_window_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] len,
   input  logic             en,
   output logic             last
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= ONE;
      end else if (load) begin
         cnt_q <= (len == '0) ? ONE : len;
      end else if (en && (cnt_q != ONE)) begin
         cnt_q <= cnt_q - ONE;
      end
   end

   assign last = (cnt_q == ONE);
endmodule

// File: rtl/slp_phase_fsm.sv
module slp_phase_fsm
   import slp_seq_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sleep_req,
   input  logic             wake_req,
   input  logic [CNT_W-1:0] cap_len,
   input  logic [CNT_W-1:0] rst_len,
   input  logic             last,
   output slp_phase_e       ph_q,
   output slp_phase_e       ph_d,
   output logic             frz_q,
   output logic             done_q,
   output logic             tmr_load,
   output logic [CNT_W-1:0] tmr_len,
   output logic             tmr_en
);
   logic frz_d, pend_q, pend_d, done_d;

   always_comb begin
      ph_d     = ph_q;
      frz_d    = frz_q;
      pend_d   = pend_q;
      done_d   = 1'b0;
      tmr_load = 1'b0;
      tmr_len  = cap_len;
      tmr_en   = 1'b0;
      unique case (ph_q)
         PH_ACTIVE: begin
            if (frz_q) begin
               ph_d     = PH_CAPTURE;
               tmr_load = 1'b1;
               pend_d   = 1'b0;
            end else if (sleep_req) begin
               frz_d = 1'b1;
            end
         end
         PH_CAPTURE: begin
            tmr_en = 1'b1;
            if (wake_req) pend_d = 1'b1;
            if (last) begin
               ph_d   = PH_HOLD;
               done_d = 1'b1;
            end
         end
         PH_HOLD: begin
            if (wake_req || pend_q) begin
               ph_d     = PH_RESTORE;
               tmr_load = 1'b1;
               tmr_len  = rst_len;
               pend_d   = 1'b0;
            end
         end
         PH_RESTORE: begin
            tmr_en = 1'b1;
            if (last) begin
               ph_d   = PH_ACTIVE;
               frz_d  = 1'b0;
               done_d = 1'b1;
            end
         end
         default: ph_d = PH_ACTIVE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_ACTIVE;
         frz_q  <= 1'b0;
         pend_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         ph_q   <= ph_d;
         frz_q  <= frz_d;
         pend_q <= pend_d;
         done_q <= done_d;
      end
   end

   // R8: a window is left only when its counter has expired
   assert_capture_stays_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_CAPTURE && !last) |=> (ph_q == PH_CAPTURE));
   assert_restore_stays_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_RESTORE && !last) |=> (ph_q == PH_RESTORE));
   // R9: a pending wake leaves hold at once
   assert_pending_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_HOLD && pend_q) |=> (ph_q == PH_RESTORE));
   // R10: done never lasts two cycles
   assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);
endmodule

// File: rtl/slp_ctrl_decode.sv
module slp_ctrl_decode
   import slp_seq_pkg::*;
#(
   parameter bit REG_OUT = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  slp_phase_e ph_in,
   output slp_ctrl_t  ctrl
);
   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ctrl <= CTRL_RESET;
            else        ctrl <= slp_decode(ph_in);
         end
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         always_comb ctrl = slp_decode(ph_in);
      end
   endgenerate
endmodule

// File: rtl/retention_sleep_seq.sv
module retention_sleep_seq
   import slp_seq_pkg::*;
#(
   parameter int CNT_W   = 8,
   parameter bit REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sleep_req,
   input  logic             wake_req,
   input  logic [CNT_W-1:0] cap_len,
   input  logic [CNT_W-1:0] rst_len,
   output logic             pwr_en,
   output logic             sw_close,
   output logic             cap_gate,
   output logic             iso_pass,
   output logic             clk_freeze,
   output logic [1:0]       phase,
   output logic             done
);
   initial begin
      assert (CNT_W >= 1 && CNT_W <= 16)
         else $error("retention_sleep_seq: CNT_W out of range");
   end

   slp_phase_e       ph_q, ph_d, dec_src;
   logic             last, tmr_load, tmr_en, frz_q, done_q;
   logic [CNT_W-1:0] tmr_len;
   slp_ctrl_t        ctrl;

   slp_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_req(wake_req),
      .cap_len(cap_len), .rst_len(rst_len), .last(last),
      .ph_q(ph_q), .ph_d(ph_d), .frz_q(frz_q), .done_q(done_q),
      .tmr_load(tmr_load), .tmr_len(tmr_len), .tmr_en(tmr_en)
   );

   slp_window_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .len(tmr_len),
      .en(tmr_en), .last(last)
   );

   assign dec_src = REG_OUT ? ph_d : ph_q;

   slp_ctrl_decode #(.REG_OUT(REG_OUT)) u_dec (
      .clk(clk), .rst_n(rst_n), .ph_in(dec_src), .ctrl(ctrl)
   );

   assign pwr_en     = ctrl.pwr_en;
   assign sw_close   = ctrl.sw_close;
   assign cap_gate   = ctrl.cap_gate;
   assign iso_pass   = ctrl.iso_pass;
   assign clk_freeze = frz_q;
   assign phase      = ph_q;
   assign done       = done_q;

   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   // R2: capture is entered only after the freeze lead cycle
   assert_freeze_lead_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && phase == 2'd1 && $past(phase) == 2'd0) |-> $past(clk_freeze));
   // R3: supply off implies switch open
   assert_off_switch_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_en |-> !sw_close);
   // R4: in active neither retention control is on
   assert_active_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == 2'd0) |-> (!cap_gate && !sw_close));
   // R5: supply drops only on entering hold
   assert_pwr_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $fell(pwr_en)) |-> (phase == 2'd2));
   // R6: isolation released only right after restore
   assert_iso_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $rose(iso_pass)) |-> ($past(phase) == 2'd3 && phase == 2'd0));
   // R7: clock held frozen outside active
   assert_freeze_covers_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != 2'd0) |-> clk_freeze);
endmodule

// File: tb/retention_sleep_seq_tb.sv
`timescale 1ns/1ps
module retention_sleep_seq_tb;
   localparam int CNT_W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sleep_req = 1'b0, wake_req = 1'b0;
   logic [CNT_W-1:0] cap_len = 8'd3, rst_len = 8'd2;
   logic pwr_en, sw_close, cap_gate, iso_pass, clk_freeze, done;
   logic [1:0] phase;

   int checks = 0, fails = 0, cyc = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   retention_sleep_seq #(.CNT_W(CNT_W), .REG_OUT(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_req(wake_req),
      .cap_len(cap_len), .rst_len(rst_len), .pwr_en(pwr_en), .sw_close(sw_close),
      .cap_gate(cap_gate), .iso_pass(iso_pass), .clk_freeze(clk_freeze),
      .phase(phase), .done(done)
   );

   // behavioural reference
   int m_ph = 0, m_cnt = 0;
   bit m_frz = 0, m_pend = 0, m_done = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_frz = 0; m_pend = 0; m_done = 0; m_cnt = 0;
      end else begin
         m_done = 0;
         if (m_ph == 0) begin
            if (m_frz) begin
               m_ph = 1; m_pend = 0;
               m_cnt = (cap_len == 0) ? 1 : int'(cap_len);
            end else if (sleep_req) m_frz = 1;
         end else if (m_ph == 1) begin
            if (wake_req) m_pend = 1;
            if (m_cnt == 1) begin m_ph = 2; m_done = 1; end
            else m_cnt = m_cnt - 1;
         end else if (m_ph == 2) begin
            if (wake_req || m_pend) begin
               m_ph = 3; m_pend = 0;
               m_cnt = (rst_len == 0) ? 1 : int'(rst_len);
            end
         end else begin
            if (m_cnt == 1) begin m_ph = 0; m_frz = 0; m_done = 1; end
            else m_cnt = m_cnt - 1;
         end
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   always @(negedge clk) begin
      cyc++;
      if (rst_n && !finished) begin
         chk("R8 phase", phase, m_ph);
         chk("R3 sw_close", sw_close, (m_ph == 1 || m_ph == 3));
         chk("R4 cap_gate", cap_gate, (m_ph == 2 || m_ph == 3));
         chk("R5 pwr_en", pwr_en, (m_ph != 2));
         chk("R6 iso_pass", iso_pass, (m_ph != 3));
         chk("R7 clk_freeze", clk_freeze, m_frz);
         chk("R10 done", done, m_done);
      end
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_phase(input int p);
      for (int i = 0; i < 300 && phase != 2'(p); i++) @(negedge clk);
   endtask

   // watchdog
   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      step(3);
      chk("R1 phase", phase, 0);
      chk("R1 pwr_en", pwr_en, 1);
      chk("R1 sw_close", sw_close, 0);
      chk("R1 cap_gate", cap_gate, 0);
      chk("R1 iso_pass", iso_pass, 1);
      chk("R1 clk_freeze", clk_freeze, 0);
      chk("R1 done", done, 0);
      rst_n = 1'b1;
      step(2);

      // R11: wake in active ignored
      wake_req = 1'b1; step(3); wake_req = 1'b0;
      chk("R11 wake in active phase", phase, 0);
      chk("R11 wake in active freeze", clk_freeze, 0);

      // S1: basic sleep, long hold
      sleep_req = 1'b1; step(1); sleep_req = 1'b0;
      chk("R2 lead freeze", clk_freeze, 1);
      chk("R2 lead phase", phase, 0);
      step(1);
      chk("R2 capture entered", phase, 1);
      cap_len = 8'd9;                 // R8: change mid-window has no effect
      wait_phase(2);
      sleep_req = 1'b1; step(5); sleep_req = 1'b0;
      chk("R9 hold waits for wake", phase, 2);
      chk("R11 sleep in hold ignored", phase, 2);
      wake_req = 1'b1; step(1); wake_req = 1'b0;
      chk("R9 wake starts restore", phase, 3);
      wait_phase(0);
      step(2);

      // S2: wake pending from capture
      cap_len = 8'd4; rst_len = 8'd5;
      sleep_req = 1'b1; step(1); sleep_req = 1'b0;
      step(2);
      wake_req = 1'b1; step(1); wake_req = 1'b0;
      wait_phase(2);
      step(1);
      chk("R9 pending wake single hold", phase, 3);
      wait_phase(0);
      chk("R6 iso back with active", iso_pass, 1);
      step(2);

      // S3: zero lengths act as one
      cap_len = 8'd0; rst_len = 8'd0;
      sleep_req = 1'b1; step(1); sleep_req = 1'b0;
      step(1);
      chk("R8 zero capture first", phase, 1);
      step(1);
      chk("R8 zero capture one cycle", phase, 2);
      wake_req = 1'b1; step(1); wake_req = 1'b0;
      chk("R8 zero restore first", phase, 3);
      step(1);
      chk("R8 zero restore one cycle", phase, 0);
      step(2);

      // S4: sleep held high continuously, wake held high
      cap_len = 8'd2; rst_len = 8'd3;
      sleep_req = 1'b1; wake_req = 1'b1;
      step(30);
      sleep_req = 1'b0; wake_req = 1'b0;
      wait_phase(0);
      step(4);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule